// File: doc/BRIEF.md
# Synchronous Burst Cache Memory

This block is a clocked static memory intended as the data store of a processor's secondary cache. It has a built-in burst address sequencer. Every synchronous input is captured on the rising clock edge: the address, write data, chip enable, both start strobes, the advance input and both lane write enables. The output enable is the only input that acts without the clock. A cycle uses one of three addresses:

- a new base address loaded by one of two start strobes;
- the next address in a four-beat burst;
- the current address again, which adds a wait state.

The data word is split into two lanes, each covering half the word, and each lane has its own active-low write enable. There are two start strobes, a processor strobe and a controller strobe, and they have different priority and different write rules. The chip enable matters only on a cycle that loads a base address. Burst beats follow an interleaved order and wrap after four beats. Read data is registered. It appears after the clock edge that samples the read, and it reaches the pins only while the output enable is low.

Top module: `burstSram`

## Requirements
- R1: Inputs act only at a rising clock edge. Read data and its drive enable change after the edge that samples the read, not before it.
- R2: If the processor strobe `procStrobeN` is low at an edge, any current burst ends and a read of `addrIn` starts. The write enables and the controller strobe have no effect on that cycle.
- R3: If the controller strobe `ctrlStrobeN` is low at an edge and `procStrobeN` is high, a new burst starts at `addrIn`. The cycle is a write when either write enable is low, and a read otherwise.
- R4: `chipEnN` is sampled only on a cycle with a strobe low. If it is high on that cycle, the block becomes deselected. While deselected, a cycle with both strobes high does no access: nothing is written and the outputs are not driven.
- R5: On a cycle with both strobes high, `advanceN` high keeps the current burst address. This adds a wait state, so the same word is read again.
- R6: On a cycle with both strobes high, `advanceN` low steps a 2-bit beat count before the access. The address used is the base address with its two lowest bits XORed with the beat count, and the upper bits held. After the fourth beat the address returns to the base.
- R7: `loWrN` low writes data bits 8:0 and `hiWrN` low writes bits 17:9. A lane whose enable is high keeps its stored value.
- R8: A write can follow a processor-strobe cycle. After the read cycle with `procStrobeN` low, a cycle with both strobes high and a write enable low writes the supplied data at the burst address.
- R9: `dataOe` is high only when the last sampled cycle was a read and `outEnN` is low now. `dataOe` follows `outEnN` without waiting for a clock edge. After a write cycle `dataOe` is low whatever the level of `outEnN`.
- R10: A synchronous reset (`rst` high at an edge) deselects the block and drops `dataOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input except `outEnN` is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Word address; loaded only on a cycle with a strobe low |
| dataIn | input | DATA_W | Write data |
| chipEnN | input | 1 | Chip enable, active low; sampled only on a cycle with a strobe low |
| procStrobeN | input | 1 | Processor start strobe, active low; highest priority; always starts a read |
| ctrlStrobeN | input | 1 | Controller start strobe, active low; read or write depending on the write enables |
| advanceN | input | 1 | Active low; steps the burst when both strobes are high |
| loWrN | input | 1 | Lower-lane write enable, active low |
| hiWrN | input | 1 | Upper-lane write enable, active low |
| outEnN | input | 1 | Output enable, active low; acts without the clock |
| dataOut | output | DATA_W | Registered read data; meaningful only while `dataOe` is high |
| dataOe | output | 1 | Tri-state drive enable for `dataOut` |

## Verification
A wrong beat count or base register shows as the wrong word on `dataOut` one edge after the next burst cycle. Wrap and interleave faults therefore need bursts from bases whose low bits are not zero. A wrong selected flag or a wrong strobe priority shows up in two places. It shows first as a wrong `dataOe` level on the cycle after the decision. It shows later as a missing or extra write, which appears only when that address is read back. A lane-mask fault is seen only on a later read of the same word, so writes that touch one lane are always read back in full.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int LANE_COUNT = 2;

  // Per-cycle command from the control to the datapath
  typedef struct packed {
    logic                  doRead;
    logic                  doWrite;
    logic [LANE_COUNT-1:0] laneWr;
  } memStrobe_t;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_LOAD_PROC,
    CYC_LOAD_CTRL,
    CYC_BURST
  } cycKind_t;

endpackage

// File: rtl/burstCtrl.sv
module burstCtrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEnN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              loWrN,
  input  logic              hiWrN,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] accessAddr
);

  localparam int CNT_W = 2;

  logic              selected;
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  beatCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic              anyWr;
  cycKind_t          cycKind;

  assign anyWr   = ~loWrN | ~hiWrN;
  assign nextCnt = advanceN ? beatCnt : beatCnt + 2'd1;

  // The processor strobe outranks the controller strobe
  always_comb begin
    if (!procStrobeN)      cycKind = CYC_LOAD_PROC;
    else if (!ctrlStrobeN) cycKind = CYC_LOAD_CTRL;
    else if (selected)     cycKind = CYC_BURST;
    else                   cycKind = CYC_IDLE;
  end

  always_comb begin
    strobe     = '0;
    accessAddr = addrIn;
    unique case (cycKind)
      CYC_LOAD_PROC: begin
        strobe.doRead = ~chipEnN;
      end
      CYC_LOAD_CTRL: begin
        strobe.doWrite = ~chipEnN & anyWr;
        strobe.doRead  = ~chipEnN & ~anyWr;
      end
      CYC_BURST: begin
        accessAddr     = {baseAddr[ADDR_W-1:CNT_W], baseAddr[CNT_W-1:0] ^ nextCnt};
        strobe.doWrite = anyWr;
        strobe.doRead  = ~anyWr;
      end
      default: ;
    endcase
    strobe.laneWr = {~hiWrN, ~loWrN} & {LANE_COUNT{strobe.doWrite}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selected <= 1'b0;
      baseAddr <= '0;
      beatCnt  <= '0;
    end else begin
      unique case (cycKind)
        CYC_LOAD_PROC, CYC_LOAD_CTRL: begin
          selected <= ~chipEnN;
          baseAddr <= addrIn;
          beatCnt  <= '0;
        end
        CYC_BURST: beatCnt <= nextCnt;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burstData.sv
module burstData
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] accessAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              readActive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANE_COUNT;

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (strobe.laneWr[g]) laneMem[accessAddr] <= dataIn[g*LANE_W +: LANE_W];
      if (strobe.doRead)    laneQ <= laneMem[accessAddr];
    end

    assign dataOut[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (rst) readActive <= 1'b0;
    else     readActive <= strobe.doRead;
  end

  assign dataOe = readActive & ~outEnN;

endmodule

// File: rtl/burstSram.sv
module burstSram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              chipEnN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              loWrN,
  input  logic              hiWrN,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  memStrobe_t        strobe;
  logic [ADDR_W-1:0] accessAddr;
  logic              readActive;

  burstCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .addrIn     (addrIn),
    .chipEnN    (chipEnN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .loWrN      (loWrN),
    .hiWrN      (hiWrN),
    .strobe     (strobe),
    .accessAddr (accessAddr)
  );

  burstData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .accessAddr (accessAddr),
    .dataIn     (dataIn),
    .outEnN     (outEnN),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .readActive (readActive)
  );

endmodule

// File: rtl/burstSramChk.sv
module burstSramChk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              chipEnN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              loWrN,
  input logic              hiWrN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              readActive
);

  assert_oe_gated_R9: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> !outEnN);

  assert_proc_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!procStrobeN && !chipEnN) |=> readActive);

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
    (procStrobeN && !ctrlStrobeN && (!loWrN || !hiWrN)) |=> !readActive);

  assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    ((!procStrobeN || !ctrlStrobeN) && chipEnN) |=> !readActive);

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (readActive && procStrobeN && ctrlStrobeN && advanceN && loWrN && hiWrN)
      |=> (readActive && $stable(dataOut)));

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !readActive);

endmodule

bind burstSram burstSramChk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .chipEnN    (chipEnN),
  .procStrobeN(procStrobeN),
  .ctrlStrobeN(ctrlStrobeN),
  .advanceN   (advanceN),
  .loWrN      (loWrN),
  .hiWrN      (hiWrN),
  .outEnN     (outEnN),
  .dataOut    (dataOut),
  .dataOe     (dataOe),
  .readActive (readActive)
);

// File: tb/test_burstSram.sv
module test_burstSram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 18;

  typedef struct packed {
    bit          p;
    bit          c;
    bit          ce;
    bit          adv;
    bit          lo;
    bit          hi;
    bit          oe;
    bit [AW-1:0] addr;
    bit [DW-1:0] data;
    bit          expOe;
    bit [3:0]    req;
  } vec_t;

  // p c ce adv lo hi oe addr data expOe req
  localparam vec_t VECS [29] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h12,18'h0,    1'b1,4'd2},  // R2 read 0x12
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 0x13
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd5},  // R5 wait 0x13
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 0x10
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 0x11
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 wrap 0x12
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h25,18'h0,    1'b1,4'd3},  // R3 read
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'h00,18'h0,    1'b0,4'd9},  // R9 oe high
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h25,18'h3FFFF,1'b0,4'd7},  // R7 low lane write
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h25,18'h0,    1'b1,4'd7},  // R7 read back
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h40,18'h2AAAA,1'b1,4'd2},  // R2 strobe priority
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,18'h15555,1'b0,4'd8},  // R8 second cycle
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h40,18'h0,    1'b1,4'd8},  // R8 read back
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h50,18'h0,    1'b0,4'd4},  // R4 deselect
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,18'h3C3C3,1'b0,4'd4},  // R4 ignored write
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h51,18'h3C3C3,1'b0,4'd4},  // R4 deselected write
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b0,4'd4},  // R4 idle suspend
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h50,18'h0,    1'b1,4'd4},  // R4 0x50 kept
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h51,18'h0,    1'b1,4'd4},  // R4 0x51 kept
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h36,18'h0,    1'b1,4'd6},  // R6 base 0x36
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 0x37
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 0x34
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,18'h0,    1'b1,4'd6},  // R6 0x35
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h6B,18'h12345,1'b0,4'd3},  // R3 write 0x6B
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,18'h0ABCD,1'b0,4'd6},  // R6 write 0x6A
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h6A,18'h0,    1'b1,4'd6},  // R6 read 0x6A
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h6B,18'h0,    1'b1,4'd3},  // R3 read 0x6B
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,18'h3FFFF,1'b0,4'd7},  // R7 lane write 0x6A
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h6A,18'h0,    1'b1,4'd7}   // R7 read back
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic          chipEnN = 1'b0;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          advanceN = 1'b1;
  logic          loWrN = 1'b1;
  logic          hiWrN = 1'b1;
  logic          outEnN = 1'b0;
  logic [DW-1:0] dataOut;
  logic          dataOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [DW-1:0] refMem [1<<AW];
  logic          refSel = 1'b0;
  logic [AW-1:0] refBase = '0;
  logic [1:0]    refCnt = '0;
  logic [DW-1:0] refQ = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burstSram #(.ADDR_W(AW), .DATA_W(DW)) i_burstSram (
    .clk(clk), .rst(rst), .addrIn(addrIn), .dataIn(dataIn), .chipEnN(chipEnN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .loWrN(loWrN), .hiWrN(hiWrN), .outEnN(outEnN), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic refAccess(input logic [AW-1:0] a, input vec_t v);
    if (!v.lo || !v.hi) begin
      if (!v.lo) refMem[a][8:0]  = v.data[8:0];
      if (!v.hi) refMem[a][17:9] = v.data[17:9];
    end else begin
      refQ = refMem[a];
    end
  endtask

  // Reference behaviour taken from the requirements
  task automatic refEdge(input vec_t v);
    vec_t rd;
    if (!v.p) begin
      refBase = v.addr; refCnt = 2'd0; refSel = !v.ce;
      rd = v; rd.lo = 1'b1; rd.hi = 1'b1;
      if (refSel) refAccess(v.addr, rd);
    end else if (!v.c) begin
      refBase = v.addr; refCnt = 2'd0; refSel = !v.ce;
      if (refSel) refAccess(v.addr, v);
    end else if (refSel) begin
      if (!v.adv) refCnt = refCnt + 2'd1;
      refAccess({refBase[AW-1:2], refBase[1:0] ^ refCnt}, v);
    end
  endtask

  task automatic step(input vec_t v, input bit doCheck);
    procStrobeN = v.p; ctrlStrobeN = v.c; chipEnN = v.ce; advanceN = v.adv;
    loWrN = v.lo; hiWrN = v.hi; outEnN = v.oe; addrIn = v.addr; dataIn = v.data;
    @(posedge clk);
    refEdge(v);
    @(negedge clk);
    if (doCheck) begin
      check(dataOe === v.expOe, v.req, "drive enable", {17'd0, dataOe}, {17'd0, v.expOe});
      if (v.expOe) check(dataOut === refQ, v.req, "read data", dataOut, refQ);
    end
  endtask

  function automatic vec_t idleVec();
    vec_t v;
    v = '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,18'h0,1'b0,4'd0};
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vec_t v;
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R10: while in reset the outputs are not driven
    check(dataOe === 1'b0, 10, "reset drive", {17'd0, dataOe}, 18'd0);
    rst = 1'b0;

    // R4: a burst cycle after reset does nothing
    v = idleVec(); v.adv = 1'b0; v.req = 4'd4;
    step(v, 1'b1);

    // Fill every word through controller-strobe write bursts
    for (int b = 0; b < (1 << AW) / 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        a = AW'(b * 4 + k);
        v = idleVec();
        v.lo = 1'b0; v.hi = 1'b0;
        v.data = {1'b0, a, ~a, 1'b1};
        if (k == 0) begin v.c = 1'b0; v.addr = a; end
        else v.adv = 1'b0;
        step(v, 1'b0);
      end
    end

    for (int i = 0; i < 29; i++) step(VECS[i], 1'b1);

    // R1: nothing changes before the sampling edge
    v = idleVec(); v.lo = 1'b0; v.c = 1'b0; v.addr = 8'h70; v.data = 18'h11111;
    step(v, 1'b0);
    procStrobeN = 1'b0; addrIn = 8'h70; loWrN = 1'b1; ctrlStrobeN = 1'b1;
    #(CLK_PERIOD/2 - 1);
    check(dataOe === 1'b0, 1, "enable before edge", {17'd0, dataOe}, 18'd0);
    @(posedge clk);
    v = idleVec(); v.p = 1'b0; v.addr = 8'h70;
    refEdge(v);
    @(negedge clk);
    check(dataOe === 1'b1, 1, "enable after edge", {17'd0, dataOe}, 18'd1);
    check(dataOut === refQ, 1, "data after edge", dataOut, refQ);

    // R9: output enable acts without a clock edge
    outEnN = 1'b1; #1;
    check(dataOe === 1'b0, 9, "async disable", {17'd0, dataOe}, 18'd0);
    outEnN = 1'b0; #1;
    check(dataOe === 1'b1, 9, "async enable", {17'd0, dataOe}, 18'd1);

    // R10: reset in the middle of a burst deselects
    @(negedge clk);
    rst = 1'b1; procStrobeN = 1'b1; advanceN = 1'b0;
    @(negedge clk);
    check(dataOe === 1'b0, 10, "reset mid burst", {17'd0, dataOe}, 18'd0);
    rst = 1'b0; refSel = 1'b0;
    v = idleVec(); v.adv = 1'b0; v.req = 4'd10;
    step(v, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule